// File: doc/BRIEF.md
# DMA Page Register and System Address Former

This block turns the 16-bit address that a DMA controller places on its address outputs into a full 24-bit system memory address. It holds eight byte-wide page registers on an I/O bus: one for each of the seven DMA channels that move data and one for memory refresh. Software writes and reads them at fixed port numbers. During a transfer the block takes the active channel number and the controller's address. It joins that address with the page of the channel and drives the system address lines and a high-byte enable.

Channels 0 to 3 move bytes. Their page fills address bits 23..16, the controller address fills bits 15..0, and the high-byte enable is the inverse of bit 0. Channels 5 to 7 move 16-bit words. Their page fills bits 23..17, the controller address is shifted up one place into bits 16..1, and both bit 0 and the high-byte enable are held low. Channel 4 only links the two controllers, so it produces no address. Because the page comes from a register and not from an adder, the controller address wraps inside its 64 KB or 128 KB window and never changes the page. Outside an acknowledged DMA or refresh cycle, all address outputs are zero.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every page register holds 0x00 and reads back as 0x00.
- R2: A write (io_wr high at a clock edge) to a page port stores io_wdata. A read (io_rd high) of that port returns the stored value on io_rdata. The ports on the I/O address are: 0x0087 channel 0, 0x0083 channel 1, 0x0081 channel 2, 0x0082 channel 3, 0x008B channel 5, 0x0089 channel 6, 0x008A channel 7, 0x008F refresh.
- R3: Writes to any other I/O address change no page register, and reads of any other address return 0x00.
- R4: With dma_ack high, refresh_ack low and dma_chan 0 to 3, sys_addr equals {page, ctl_addr} and sys_bhe equals the inverse of ctl_addr[0].
- R5: With dma_ack high, refresh_ack low and dma_chan 5 to 7, sys_addr equals {page[7:1], ctl_addr, 0} and sys_bhe is 0. Page bit 0 has no effect on the address.
- R6: An all-ones controller address leaves the page bits of sys_addr equal to the page register. No carry reaches the page.
- R7: With dma_ack high and dma_chan 4, sys_addr and sys_bhe are 0.
- R8: With both dma_ack and refresh_ack low, sys_addr and sys_bhe are 0.
- R9: refresh_ack high selects the refresh page with byte alignment ({page, ctl_addr}, sys_bhe equal to the inverse of ctl_addr[0]). This takes priority over dma_ack and dma_chan.
- R10: io_rdata is 0x00 whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read enable |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| dma_ack | input | 1 | A DMA channel is acknowledged |
| dma_chan | input | 3 | Number of the acknowledged channel |
| refresh_ack | input | 1 | Refresh cycle in progress |
| ctl_addr | input | 16 | Address from the DMA controller |
| sys_addr | output | 24 | System memory address, bit 0 included |
| sys_bhe | output | 1 | High-byte enable |

## Verification
The bench gives each channel a distinct page, with an odd page on a word channel. A design that let page bit 0 through would then show a wrong bit 16, and a design with the port decode swapped between channels would return the wrong byte. An all-ones controller address on a byte channel and on a word channel checks that no carry leaks into the page. A design that computed the address with an adder would show an incremented page. Channel 4 with acknowledge, the idle state, and refresh together with a word-channel acknowledge check that cascade produces nothing, that idle outputs stay zero, and that refresh wins. Writes to unused ports in the decoded range, followed by reads of the real ports, would show a decode that is too loose.

// File: rtl/dma_pg_pkg.sv
// Package: sizes and port map shared by the page-register address former.
// Assumes eight page slots: slot 4, which channel 4 never uses, holds the refresh page.
package dma_pg_pkg;
    localparam int PAGE_W   = 8;
    localparam int CTL_AW   = 16;
    localparam int SYS_AW   = PAGE_W + CTL_AW;
    localparam int IO_AW    = 16;
    localparam int NSLOT    = 8;
    localparam int SLOT_W   = $clog2(NSLOT);
    localparam int RFSH_SLOT = 4;
    localparam logic [IO_AW-1:0] PAGE_BASE = 16'h0080;

    // Low nibble of the I/O port that holds the page for a given slot.
    function automatic logic [3:0] slot_port_lo(input int slot);
        case (slot)
            0: return 4'h7;
            1: return 4'h3;
            2: return 4'h1;
            3: return 4'h2;
            4: return 4'hF;
            5: return 4'hB;
            6: return 4'h9;
            default: return 4'hA;
        endcase
    endfunction
endpackage

// File: rtl/dma_page_regfile.sv
// Page register file: one byte per slot, written and read at fixed I/O ports.
// Assumes a full I/O address compare; unmatched ports are neither written nor read.
module dma_page_regfile
    import dma_pg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IO_AW-1:0]              io_addr,
    input  logic                          io_wr,
    input  logic                          io_rd,
    input  logic [PAGE_W-1:0]             io_wdata,
    output logic [PAGE_W-1:0]             io_rdata,
    output logic [NSLOT-1:0][PAGE_W-1:0]  page_q
);
    logic [NSLOT-1:0] hit;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Port match for this slot.
        assign hit[s] = (io_addr == (PAGE_BASE | IO_AW'(slot_port_lo(s))));

        // Store the write data when this slot's port is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                page_q[s] <= '0;
            else if (io_wr && hit[s])
                page_q[s] <= io_wdata;
        end
    end

    // Readback mux: the matching slot's byte, or zero.
    always_comb begin
        io_rdata = '0;
        if (io_rd)
            for (int s = 0; s < NSLOT; s++)
                if (hit[s]) io_rdata = page_q[s];
    end

    // At most one slot answers a port.
    assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // Page bytes hold when nothing is written.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(page_q));
    // Reset clears every page.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (page_q == '0));
endmodule

// File: rtl/dma_addr_former.sv
// Address former: joins the selected page with the controller address.
// Byte slots take the page on A23..A16; word slots shift the controller address up one bit.
// Assumes channel 4 is the cascade and never drives an address.
module dma_addr_former
    import dma_pg_pkg::*;
(
    input  logic [NSLOT-1:0][PAGE_W-1:0]  page_q,
    input  logic                          dma_ack,
    input  logic [SLOT_W-1:0]             dma_chan,
    input  logic                          refresh_ack,
    input  logic [CTL_AW-1:0]             ctl_addr,
    output logic [SYS_AW-1:0]             sys_addr,
    output logic                          sys_bhe
);
    localparam logic [SLOT_W-1:0] CASCADE = SLOT_W'(RFSH_SLOT);

    logic [PAGE_W-1:0] pg;
    logic              word_ch;

    // Pick the page and the alignment for the active cycle.
    always_comb begin
        pg      = refresh_ack ? page_q[RFSH_SLOT] : page_q[dma_chan];
        word_ch = !refresh_ack && dma_chan[SLOT_W-1] && (dma_chan != CASCADE);
    end

    // Form the address and high-byte enable; zero outside acknowledged cycles.
    always_comb begin
        sys_addr = '0;
        sys_bhe  = 1'b0;
        if (refresh_ack || (dma_ack && dma_chan != CASCADE)) begin
            if (word_ch) begin
                sys_addr = {pg[PAGE_W-1:1], ctl_addr, 1'b0};
                sys_bhe  = 1'b0;
            end else begin
                sys_addr = {pg, ctl_addr};
                sys_bhe  = ~ctl_addr[0];
            end
        end
    end
endmodule

// File: rtl/dma_page_addr_gen.sv
// Top: page registers on an I/O bus plus 24-bit DMA system address formation.
// Assumes the DMA controllers and arbitration sit outside; inputs are sampled as given.
module dma_page_addr_gen
    import dma_pg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [PAGE_W-1:0]    io_wdata,
    output logic [PAGE_W-1:0]    io_rdata,
    input  logic                 dma_ack,
    input  logic [SLOT_W-1:0]    dma_chan,
    input  logic                 refresh_ack,
    input  logic [CTL_AW-1:0]    ctl_addr,
    output logic [SYS_AW-1:0]    sys_addr,
    output logic                 sys_bhe
);
    logic [NSLOT-1:0][PAGE_W-1:0] page_q;

    dma_page_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .page_q   (page_q)
    );

    dma_addr_former u_form (
        .page_q      (page_q),
        .dma_ack     (dma_ack),
        .dma_chan    (dma_chan),
        .refresh_ack (refresh_ack),
        .ctl_addr    (ctl_addr),
        .sys_addr    (sys_addr),
        .sys_bhe     (sys_bhe)
    );

    // Idle: no address leaves the block.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_ack && !refresh_ack) |-> (sys_addr == '0 && !sys_bhe));
    // Cascade channel produces nothing.
    assert_cascade_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !refresh_ack && dma_chan == 3'd4) |-> (sys_addr == '0 && !sys_bhe));
    // Word channels are always even with the high-byte enable low.
    assert_word_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !refresh_ack && dma_chan > 3'd4) |-> (!sys_addr[0] && !sys_bhe));
    // Byte channels: high-byte enable is the inverse of A0.
    assert_byte_bhe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !refresh_ack && dma_chan < 3'd4) |-> (sys_bhe == !sys_addr[0]));
    // Controller address bits always appear unchanged on the low lines.
    assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !refresh_ack && dma_chan < 3'd4) |-> (sys_addr[15:0] == ctl_addr));
    // Read data is quiet without a read.
    assert_rd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0));
endmodule

// File: tb/dma_page_addr_gen_test.sv
module dma_page_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        dma_ack = 1'b0, refresh_ack = 1'b0;
    logic [2:0]  dma_chan = '0;
    logic [15:0] ctl_addr = '0;
    logic [23:0] sys_addr;
    logic        sys_bhe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_page_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dma_ack(dma_ack), .dma_chan(dma_chan),
        .refresh_ack(refresh_ack), .ctl_addr(ctl_addr), .sys_addr(sys_addr), .sys_bhe(sys_bhe)
    );

    typedef struct packed {
        logic        rf;
        logic        dk;
        logic [2:0]  ch;
        logic [15:0] ctl;
        logic [23:0] ea;
        logic        eb;
    } vec_t;

    // Pages: ch0 12, ch1 34, ch2 56, ch3 78, ch5 9B, ch6 A4, ch7 C7, refresh E1.
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        {1'b0, 1'b1, 3'd0, 16'h1234, 24'h121234, 1'b1},  // R4
        {1'b0, 1'b1, 3'd1, 16'hABCD, 24'h34ABCD, 1'b0},  // R4
        {1'b0, 1'b1, 3'd2, 16'hFFFF, 24'h56FFFF, 1'b0},  // R6
        {1'b0, 1'b1, 3'd3, 16'h0001, 24'h780001, 1'b0},  // R4
        {1'b0, 1'b1, 3'd5, 16'h1234, 24'h9A2468, 1'b0},  // R5 odd page
        {1'b0, 1'b1, 3'd6, 16'hFFFF, 24'hA5FFFE, 1'b0},  // R6 word
        {1'b0, 1'b1, 3'd7, 16'h8001, 24'hC70002, 1'b0},  // R5
        {1'b0, 1'b1, 3'd4, 16'h5555, 24'h000000, 1'b0},  // R7
        {1'b0, 1'b0, 3'd0, 16'h1234, 24'h000000, 1'b0},  // R8
        {1'b1, 1'b0, 3'd0, 16'h00FE, 24'hE100FE, 1'b1},  // R9
        {1'b1, 1'b1, 3'd5, 16'h0003, 24'hE10003, 1'b0},  // R9 priority
        {1'b0, 1'b1, 3'd0, 16'h0000, 24'h120000, 1'b1}   // R4
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        chk(req, {24'h0, io_rdata}, {24'h0, exp});
        io_rd = 1'b0;
    endtask

    localparam logic [15:0] PORTS [8] = '{16'h0087, 16'h0083, 16'h0081, 16'h0082,
                                          16'h008B, 16'h0089, 16'h008A, 16'h008F};
    localparam logic [7:0]  VALS  [8] = '{8'h12, 8'h34, 8'h56, 8'h78,
                                          8'h9B, 8'hA4, 8'hC7, 8'hE1};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 8; i++) io_read_chk("R1 reset page", PORTS[i], 8'h00);
        @(negedge clk) begin dma_ack = 1'b1; dma_chan = 3'd0; ctl_addr = 16'h4321; end
        #1 chk("R1 reset addr", {8'h0, sys_addr}, 32'h004321);
        dma_ack = 1'b0;
        // R2: write and read back every page port
        for (int i = 0; i < 8; i++) io_write(PORTS[i], VALS[i]);
        for (int i = 0; i < 8; i++) io_read_chk("R2 readback", PORTS[i], VALS[i]);
        // R3: unused ports in the same range
        io_write(16'h0084, 8'hFF);
        io_write(16'h0080, 8'hFF);
        io_write(16'h008C, 8'hFF);
        io_write(16'h0187, 8'hFF);
        io_read_chk("R3 unused read", 16'h0084, 8'h00);
        io_read_chk("R3 alias read", 16'h0187, 8'h00);
        for (int i = 0; i < 8; i++) io_read_chk("R3 page unchanged", PORTS[i], VALS[i]);
        // R10: no read, no data
        @(negedge clk) begin io_addr = 16'h0087; io_rd = 1'b0; end
        #1 chk("R10 quiet rdata", {24'h0, io_rdata}, 32'h0);
        // Vector table: R4..R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            refresh_ack = VEC[i].rf; dma_ack = VEC[i].dk;
            dma_chan = VEC[i].ch; ctl_addr = VEC[i].ctl;
            #1;
            chk($sformatf("R4-9 vector %0d addr", i), {8'h0, sys_addr}, {8'h0, VEC[i].ea});
            chk($sformatf("R4-9 vector %0d bhe", i), {31'h0, sys_bhe}, {31'h0, VEC[i].eb});
        end
        // R5: changing page bit 0 of a word channel leaves the address alone
        io_write(16'h008B, 8'h9A);
        @(negedge clk) begin refresh_ack = 1'b0; dma_ack = 1'b1; dma_chan = 3'd5; ctl_addr = 16'h1234; end
        #1 chk("R5 page bit0 ignored", {8'h0, sys_addr}, 32'h9A2468);
        // R1: second reset clears pages while running
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        dma_chan = 3'd7; ctl_addr = 16'h0010;
        #1 chk("R1 reset clears ch7", {8'h0, sys_addr}, 32'h000020);
        dma_ack = 1'b0;
        io_read_chk("R1 reset clears refresh", 16'h008F, 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule